// File: doc/BRIEF.md
# Search Window Row Fetch and Vertical Alignment

This block feeds a chain of four one-bit block-matching arrays from a banked on-chip store that holds a binary search window. The window is 48 lines by 96 pixels and serves four neighbouring 16x16 blocks at once. A sequencer walks through 33 search lines. For each line it issues read addresses to sixteen memory ports: eight banks with two ports each. The 16 rows that come back are in bank order, not in block-row order. A datapath rotates them so that output row k always carries window line s+k, where s is the search line.

Each search line has two line-start cycles and then 32 steady cycles. In the two line-start cycles, the aligned 32-bit words are split into 16-pixel halves and loaded into the four arrays, two arrays per cycle. In the 32 steady cycles, a column selector sends one 16-pixel column per cycle to the first array of the chain. The memories have a one-cycle read latency. Rotation and column selection share one registered stage. Every output therefore appears two cycles after the state that issued its address.

Top module: `sw_fetch_align`

## Requirements
- R1: While reset is asserted and after its release with no start, rd_en, load_en, col_vld and done are all low.
- R2: Window line g, pixel x lives in bank (g mod 16)/2, word (g/16)*6 + (x/32)*2 + (g mod 2), bit x mod 32. Port q of bank b (address slice 2b+q) always reads the needed line whose value mod 16 is 2b+q. For search line s it reads word column 0 in line-start cycle 1, column 1 in line-start cycle 2 and column 2 in steady cycles.
- R3: A start sampled while idle begins a pass of 33 search lines. Each line takes 2 line-start cycles and then 32 steady cycles, back to back, for 1122 fetch cycles in total. rd_en is high exactly in those cycles. The first outputs appear two clock edges after the edge that sampled start.
- R4: Line-start cycle 1 shows load_en = 4'b1100 (bit 3 = fourth array, bit 2 = third array). Bit 16k+i of lo_rows is pixel i of window line s+k, and bit 16k+i of hi_rows is pixel 16+i.
- R5: Line-start cycle 2 shows load_en = 4'b0011 (bit 1 = second array, bit 0 = first array). lo_rows carries pixels 32+i and hi_rows carries pixels 48+i, with the same row order as in R4.
- R6: Steady cycle c (0..31) shows col_vld = 1 and col_idx = c. Bit k of col_data is pixel 64+c of window line s+k.
- R7: out_line equals s on every valid output. Row alignment holds for every s, including lines whose 16 rows straddle two regions (the rows are rotated by s mod 16).
- R8: The sixteen read addresses stay constant through all 32 steady cycles of a line.
- R9: done is a one-cycle pulse in the cycle after the last column of search line 32, and rd_en is low by then.
- R10: A start asserted while a pass is running has no effect on that pass's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass when idle |
| rd_en | output | 1 | Read enable for all memory ports |
| rd_addr | output | 80 | Sixteen 5-bit word addresses, slice 2b+q for port q of bank b |
| rd_data | input | 512 | Sixteen 32-bit read words, slice 2b+q, one cycle after the address |
| load_en | output | 4 | Array load strobes, bit 0 = first array |
| lo_rows | output | 256 | Low 16-bit halves of the 16 aligned rows |
| hi_rows | output | 256 | High 16-bit halves of the 16 aligned rows |
| col_vld | output | 1 | A column is present on col_data |
| col_data | output | 16 | Column for the first array, bit k = row k |
| col_idx | output | 5 | Bit position of the current column |
| out_line | output | 6 | Search line of the current output |
| done | output | 1 | Pass-complete pulse |

## Verification
The bench targets search lines whose 16 rows straddle a region boundary (lines 1, 15, 17 and 31, for example). A wrong rotate amount or a wrong region select in the address would deliver rows that are off by one region or shifted by one row. One window pattern encodes each line's number in its pixels, so a misrouted row cannot pass by accident. The bench also times every output against the start edge, which catches an off-by-one in the read-latency pipeline, a missing line-start cycle or a gap between lines. It asserts start at the last steady cycle and in the middle of a pass: a design that re-arms there would shift the pass or restart it.

// File: rtl/sw_fetch_pkg.sv
package sw_fetch_pkg;

  // Phase of the fetch sequencer; travels with the read data as a tag.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LS1  = 2'd1,
    PH_LS2  = 2'd2,
    PH_RUN  = 2'd3
  } sw_phase_e;

endpackage

// File: rtl/sw_fetch_seq.sv
module sw_fetch_seq
  import sw_fetch_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int NUM_BANKS = 8,
  parameter int WORD_W    = 32,
  parameter int REGIONS   = 3,
  parameter int LINE_W    = 6,
  parameter int BIT_W     = 5,
  parameter int AW        = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output logic                          rd_en,
  output logic [2*NUM_BANKS*AW-1:0]     rd_addr,
  output sw_phase_e                     tag_phase,
  output logic [LINE_W-1:0]             tag_line,
  output logic [BIT_W-1:0]              tag_bit
);

  localparam int NPORTS    = 2 * NUM_BANKS;
  localparam int LPB       = ROWS / NUM_BANKS;       // lines per bank per region
  localparam int WPL       = 3;                      // word columns per window line
  localparam int RSTRIDE   = LPB * WPL;              // words per region in a bank
  localparam int DEPTH     = REGIONS * RSTRIDE;
  localparam int LAST_LINE = (REGIONS - 1) * ROWS;
  localparam int LAST_BIT  = WORD_W - 1;

  sw_phase_e           phase_q, phase_d;
  logic [LINE_W-1:0]   line_q, line_d;
  logic                line_en;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic                bit_en;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    line_d  = line_q;
    line_en = 1'b0;
    bit_d   = '0;
    bit_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_LS1;
          line_d  = '0;
          line_en = 1'b1;
        end
      end
      PH_LS1: phase_d = PH_LS2;
      PH_LS2: begin
        phase_d = PH_RUN;
        bit_d   = '0;
        bit_en  = 1'b1;
      end
      PH_RUN: begin
        if (bit_q == BIT_W'(LAST_BIT)) begin
          if (line_q == LINE_W'(LAST_LINE)) begin
            phase_d = PH_IDLE;
          end else begin
            phase_d = PH_LS1;
            line_d  = line_q + 1'b1;
            line_en = 1'b1;
          end
        end else begin
          bit_d  = bit_q + 1'b1;
          bit_en = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      line_q  <= '0;
      bit_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (line_en) line_q <= line_d;
      if (bit_en)  bit_q  <= bit_d;
    end
  end

  // Address generation: port j reads the needed line whose index mod ROWS is j.
  // Lines below the rotate point come from the next region down.
  always_comb begin
    int soff;
    int sreg;
    int reg_i;
    int col_i;
    int a_i;
    soff = int'(line_q) % ROWS;
    sreg = int'(line_q) / ROWS;
    unique case (phase_q)
      PH_LS1:  col_i = 0;
      PH_LS2:  col_i = 1;
      default: col_i = 2;
    endcase
    for (int j = 0; j < NPORTS; j++) begin
      reg_i = (j >= soff) ? sreg : sreg + 1;
      a_i   = reg_i * RSTRIDE + col_i * LPB + (j % LPB);
      rd_addr[j*AW +: AW] = AW'(a_i);
    end
  end

  assign rd_en     = (phase_q != PH_IDLE);
  assign tag_phase = phase_q;
  assign tag_line  = line_q;
  assign tag_bit   = bit_q;

  // R3: line start runs two cycles in order, then steady from bit 0
  assert_ls_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_LS1 |=> phase_q == PH_LS2);
  assert_run_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_LS2 |=> (phase_q == PH_RUN && bit_q == '0));
  assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> line_q <= LINE_W'(LAST_LINE));

  // R8: addresses held over the steady cycles of a line
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && bit_q != '0) |-> $stable(rd_addr));

  // R10: a busy start does not disturb the running line
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && start && bit_q != BIT_W'(LAST_BIT)) |=> $stable(line_q));

  // R2: every issued address lies inside the bank
  for (genvar j = 0; j < NPORTS; j++) begin : g_addr_chk
    assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> rd_addr[j*AW +: AW] < AW'(DEPTH));
  end

endmodule

// File: rtl/sw_row_rot.sv
module sw_row_rot #(
  parameter int N  = 16,
  parameter int SW = 4
) (
  input  logic [N-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [N-1:0]  dout
);

  // Output entry k takes input entry (k + amt) mod N.
  always_comb begin
    for (int k = 0; k < N; k++) begin
      dout[k] = din[(k + int'(amt)) % N];
    end
  end

endmodule

// File: rtl/sw_col_pick.sv
module sw_col_pick #(
  parameter int ROWS   = 16,
  parameter int WORD_W = 32,
  parameter int BIT_W  = 5
) (
  input  logic [ROWS*WORD_W-1:0] rows,
  input  logic [BIT_W-1:0]       sel,
  output logic [ROWS-1:0]        col
);

  always_comb begin
    for (int k = 0; k < ROWS; k++) begin
      col[k] = rows[k*WORD_W + int'(sel)];
    end
  end

endmodule

// File: rtl/sw_fetch_path.sv
module sw_fetch_path
  import sw_fetch_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int WORD_W    = 32,
  parameter int LINE_W    = 6,
  parameter int BIT_W     = 5,
  parameter int LAST_LINE = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  sw_phase_e                      tag_phase,
  input  logic [LINE_W-1:0]              tag_line,
  input  logic [BIT_W-1:0]               tag_bit,
  input  logic [ROWS*WORD_W-1:0]         rd_data,
  output logic [3:0]                     load_en,
  output logic [ROWS*(WORD_W/2)-1:0]     lo_rows,
  output logic [ROWS*(WORD_W/2)-1:0]     hi_rows,
  output logic                           col_vld,
  output logic [ROWS-1:0]                col_data,
  output logic [BIT_W-1:0]               col_idx,
  output logic [LINE_W-1:0]              out_line,
  output logic                           done
);

  localparam int HALF     = WORD_W / 2;
  localparam int RW       = $clog2(ROWS);
  localparam int LAST_BIT = WORD_W - 1;

  // Tag stage, matched to the one-cycle memory read latency
  sw_phase_e           p1_phase;
  logic [LINE_W-1:0]   p1_line;
  logic [BIT_W-1:0]    p1_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_phase <= PH_IDLE;
      p1_line  <= '0;
      p1_bit   <= '0;
    end else begin
      p1_phase <= tag_phase;
      p1_line  <= tag_line;
      p1_bit   <= tag_bit;
    end
  end

  // Vertical alignment: one rotator per bit position, shared amount
  logic [RW-1:0]              rot_amt;
  logic [ROWS*WORD_W-1:0]     aligned;

  assign rot_amt = p1_line[RW-1:0];

  for (genvar c = 0; c < WORD_W; c++) begin : g_rot
    logic [ROWS-1:0] v_in;
    logic [ROWS-1:0] v_out;
    for (genvar k = 0; k < ROWS; k++) begin : g_row
      assign v_in[k]                = rd_data[k*WORD_W + c];
      assign aligned[k*WORD_W + c]  = v_out[k];
    end
    sw_row_rot #(.N(ROWS), .SW(RW)) u_rot (
      .din  (v_in),
      .amt  (rot_amt),
      .dout (v_out)
    );
  end

  logic [ROWS-1:0] col_d;

  sw_col_pick #(.ROWS(ROWS), .WORD_W(WORD_W), .BIT_W(BIT_W)) u_pick (
    .rows (aligned),
    .sel  (p1_bit),
    .col  (col_d)
  );

  // Next-state for the output stage
  logic [3:0]              load_en_d;
  logic                    ld_cap;
  logic [ROWS*HALF-1:0]    lo_d, hi_d;
  logic                    col_vld_d;
  logic                    line_cap;
  logic                    done_d;

  always_comb begin
    load_en_d = 4'b0000;
    if (p1_phase == PH_LS1) load_en_d = 4'b1100;
    if (p1_phase == PH_LS2) load_en_d = 4'b0011;
    ld_cap    = (p1_phase == PH_LS1) || (p1_phase == PH_LS2);
    col_vld_d = (p1_phase == PH_RUN);
    line_cap  = (p1_phase != PH_IDLE);
    for (int k = 0; k < ROWS; k++) begin
      lo_d[k*HALF +: HALF] = aligned[k*WORD_W +: HALF];
      hi_d[k*HALF +: HALF] = aligned[k*WORD_W + HALF +: HALF];
    end
    done_d = col_vld && (col_idx == BIT_W'(LAST_BIT)) &&
             (out_line == LINE_W'(LAST_LINE));
  end

  // Output registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_en  <= '0;
      lo_rows  <= '0;
      hi_rows  <= '0;
      col_vld  <= 1'b0;
      col_data <= '0;
      col_idx  <= '0;
      out_line <= '0;
      done     <= 1'b0;
    end else begin
      load_en <= load_en_d;
      col_vld <= col_vld_d;
      done    <= done_d;
      if (ld_cap) begin
        lo_rows <= lo_d;
        hi_rows <= hi_d;
      end
      if (col_vld_d) begin
        col_data <= col_d;
        col_idx  <= p1_bit;
      end
      if (line_cap) out_line <= p1_line;
    end
  end

  // R4: loads come in array pairs and never overlap a column
  assert_load_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_en[3] & load_en[2], load_en[1] & load_en[0], col_vld}) &&
    (load_en[3] == load_en[2]) && (load_en[1] == load_en[0]));

  // R5: the second pair follows the first pair directly
  assert_pair_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en[3] |=> load_en[0]);

  // R6: columns start at 0 after line start and step by one
  assert_col_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en[0] |=> (col_vld && col_idx == '0));
  assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && col_idx != BIT_W'(LAST_BIT)) |=>
      (col_vld && col_idx == $past(col_idx) + 1'b1));

  // R9: done is a single pulse right after the final column
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!col_vld && $past(col_vld)));

endmodule

// File: rtl/sw_fetch_align.sv
module sw_fetch_align
  import sw_fetch_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int NUM_BANKS = 8,
  parameter int WORD_W    = 32,
  parameter int REGIONS   = 3,
  parameter int LINE_W    = $clog2((REGIONS - 1) * ROWS + 1),
  parameter int BIT_W     = $clog2(WORD_W),
  parameter int AW        = $clog2(REGIONS * (ROWS / NUM_BANKS) * 3)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  output logic                            rd_en,
  output logic [2*NUM_BANKS*AW-1:0]       rd_addr,
  input  logic [2*NUM_BANKS*WORD_W-1:0]   rd_data,
  output logic [3:0]                      load_en,
  output logic [ROWS*(WORD_W/2)-1:0]      lo_rows,
  output logic [ROWS*(WORD_W/2)-1:0]      hi_rows,
  output logic                            col_vld,
  output logic [ROWS-1:0]                 col_data,
  output logic [BIT_W-1:0]                col_idx,
  output logic [LINE_W-1:0]               out_line,
  output logic                            done
);

  localparam int LAST_LINE = (REGIONS - 1) * ROWS;

  sw_phase_e          tag_phase;
  logic [LINE_W-1:0]  tag_line;
  logic [BIT_W-1:0]   tag_bit;

  sw_fetch_seq #(
    .ROWS(ROWS), .NUM_BANKS(NUM_BANKS), .WORD_W(WORD_W), .REGIONS(REGIONS),
    .LINE_W(LINE_W), .BIT_W(BIT_W), .AW(AW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .tag_phase (tag_phase),
    .tag_line  (tag_line),
    .tag_bit   (tag_bit)
  );

  sw_fetch_path #(
    .ROWS(ROWS), .WORD_W(WORD_W), .LINE_W(LINE_W), .BIT_W(BIT_W),
    .LAST_LINE(LAST_LINE)
  ) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .tag_phase (tag_phase),
    .tag_line  (tag_line),
    .tag_bit   (tag_bit),
    .rd_data   (rd_data),
    .load_en   (load_en),
    .lo_rows   (lo_rows),
    .hi_rows   (hi_rows),
    .col_vld   (col_vld),
    .col_data  (col_data),
    .col_idx   (col_idx),
    .out_line  (out_line),
    .done      (done)
  );

  // R1: nothing is read or driven out while idle after reset
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> ##2 (load_en == 4'b0000 && !col_vld));

endmodule

// File: tb/sw_fetch_align_bench.sv
`timescale 1ns/1ps
module sw_fetch_align_bench;

  localparam int NB    = 8;
  localparam int NP    = 16;
  localparam int WW    = 32;
  localparam int AW    = 5;
  localparam int DEPTH = 18;
  localparam int WINL  = 48;
  localparam int WINW  = 96;
  localparam int LPC   = 34;          // cycles per search line
  localparam int NCYC  = 33 * LPC;    // 1122 fetch cycles

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              rd_en;
  logic [NP*AW-1:0]  rd_addr;
  logic [NP*WW-1:0]  rd_data;
  logic [3:0]        load_en;
  logic [255:0]      lo_rows;
  logic [255:0]      hi_rows;
  logic              col_vld;
  logic [15:0]       col_data;
  logic [4:0]        col_idx;
  logic [5:0]        out_line;
  logic              done;

  int n_chk;
  int n_fail;

  logic [WW-1:0] mem [NB][DEPTH];
  logic [WW-1:0] rword [NP];
  bit            win [WINL][WINW];

  sw_fetch_align u_sw_fetch_align (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .load_en(load_en), .lo_rows(lo_rows), .hi_rows(hi_rows),
    .col_vld(col_vld), .col_data(col_data), .col_idx(col_idx),
    .out_line(out_line), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Banked store: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (rd_en) begin
      for (int j = 0; j < NP; j++) rword[j] <= mem[j/2][rd_addr[j*AW +: AW]];
    end
  end
  always_comb begin
    for (int j = 0; j < NP; j++) rd_data[j*WW +: WW] = rword[j];
  end

  task automatic chk(input string req, input logic [511:0] got, input logic [511:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Window contents per pattern; store them using the R2 layout
  task automatic fill(input int pat);
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < DEPTH; a++) mem[b][a] = '0;
    for (int g = 0; g < WINL; g++) begin
      for (int x = 0; x < WINW; x++) begin
        case (pat)
          0: win[g][x] = 1'($urandom());
          1: win[g][x] = 1'((g >> (x % 6)) & 1);
          default: win[g][x] = 1'((g + x) & 1);
        endcase
        mem[(g % 16) / 2][(g / 16) * 6 + (x / 32) * 2 + (g % 2)][x % 32] = win[g][x];
      end
    end
  endtask

  function automatic logic [255:0] exp_rows(input int s, input int base);
    logic [255:0] r;
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < 16; i++) r[k*16 + i] = win[s + k][base + i];
    return r;
  endfunction

  function automatic logic [15:0] exp_col(input int s, input int c);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = win[s + k][64 + c];
    return r;
  endfunction

  function automatic logic [NP*AW-1:0] exp_addr(input int s, input int col);
    logic [NP*AW-1:0] r;
    for (int j = 0; j < NP; j++) begin
      int g;
      g = s + ((j - (s % 16) + 16) % 16);
      r[j*AW +: AW] = AW'((g / 16) * 6 + col * 2 + (g % 2));
    end
    return r;
  endfunction

  // One full pass; inj_a / inj_b are cycles at which start is raised while busy
  task automatic run_pass(input int inj_a, input int inj_b);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < NCYC + 5; n++) begin
      int i, s, p;
      logic [3:0] e_ld;
      logic e_cv, e_dn, e_re;
      string tag;
      i    = n - 2;
      s    = 0;
      p    = 0;
      e_ld = 4'b0000;
      e_cv = 1'b0;
      e_dn = (n == NCYC + 2);
      e_re = (n < NCYC);
      if (i >= 0 && i < NCYC) begin
        s = i / LPC;
        p = i % LPC;
        if (p == 0) e_ld = 4'b1100;
        else if (p == 1) e_ld = 4'b0011;
        else e_cv = 1'b1;
      end
      tag = e_dn ? "R9" : ((inj_a >= 0) ? "R3 R10" : "R3");
      chk(tag, 512'({load_en, col_vld, done, rd_en}), 512'({e_ld, e_cv, e_dn, e_re}));
      if (i >= 0 && i < NCYC) begin
        if (p == 0)
          chk("R2 R4 R7", 512'({out_line, lo_rows, hi_rows}),
              512'({6'(s), exp_rows(s, 0), exp_rows(s, 16)}));
        else if (p == 1)
          chk("R2 R5 R7", 512'({out_line, lo_rows, hi_rows}),
              512'({6'(s), exp_rows(s, 32), exp_rows(s, 48)}));
        else
          chk("R6 R7", 512'({out_line, col_idx, col_data}),
              512'({6'(s), 5'(p - 2), exp_col(s, p - 2)}));
      end
      if (n < NCYC) begin
        int sa, pa;
        sa = n / LPC;
        pa = n % LPC;
        if (pa == 0) chk("R2", 512'(rd_addr), 512'(exp_addr(sa, 0)));
        if (pa == 1) chk("R2", 512'(rd_addr), 512'(exp_addr(sa, 1)));
        if (pa == 2) chk("R2", 512'(rd_addr), 512'(exp_addr(sa, 2)));
        if (pa == LPC - 1) chk("R8", 512'(rd_addr), 512'(exp_addr(sa, 2)));
      end
      start = (n == inj_a) || (n == inj_b);
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    start  = 1'b0;
    fill(0);
    repeat (3) @(negedge clk);
    chk("R1", 512'({load_en, col_vld, done, rd_en}), 512'(7'd0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", 512'({load_en, col_vld, done, rd_en}), 512'(7'd0));

    run_pass(-1, -1);               // random window
    fill(1);
    run_pass(500, NCYC - 1);        // line-coded window, busy starts
    fill(2);
    run_pass(-1, -1);               // checkerboard window

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog got=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule